// File: doc/BRIEF.md
# Bidirectional Pin Port with Change Detection

This block controls a small group of general-purpose pins through a byte-wide register interface. Software sets each pin's direction, loads an output latch, turns on per-pin pull-ups under a shared disable, marks pins as analog so that they read back as zero, and picks which pins are watched for a change. One pin is input only. It can never be driven and never has a pull-up.

Pin levels pass through a two-flop synchronizer before they are read or compared. Every access to the port register records the pin levels as the reference value. A watched pin whose level differs from that reference sets a sticky change flag. An interrupt controller or a wake-up circuit outside this block uses the flag. Software clears the flag. It must first access the port so that the reference matches the pins again, because the flag is set again on every cycle in which a difference remains.

Registers are selected by `bus_addr`: 0 port, 1 direction, 2 pull-up enables, 3 change enables, 4 analog select, 5 control. Bit n of a register belongs to pin n. Bits at or above the pin count read 0.

Top module: `ioc_port`

## Requirements
- R1: After reset, all pins are inputs (direction register reads 0x3F, `pad_oe` = 0), the pull-up enables read 0x37, the control register reads 0x01 (global pull-up disable set, flag clear), the change enables read 0, and `pad_pu` = 0.
- R2: A direction bit of 0 drives the latch bit on `pad_out` with `pad_oe` high. A direction bit of 1 turns the driver off. A write to address 1 takes effect on `pad_oe` in the cycle after the write.
- R3: Pin 3 is input only. Its direction bit always reads 1, its pull-up enable bit always reads 0, and `pad_oe[3]` and `pad_pu[3]` are always 0.
- R4: A read of address 0 returns the synchronized pin levels on `bus_rdata` in the cycle after `bus_rd`. A pin change is visible after two clock edges.
- R5: A write to address 0 loads the latch bit by bit. A bit with `bus_wmask` set takes `bus_wdata`. A bit with `bus_wmask` clear takes the pin value that a port read would return at that time.
- R6: `pad_pu[n]` is 1 only when pull-up enable bit n is 1, the global disable (control bit 0) is 0, and pin n is an input.
- R7: A pin whose bit is set in the analog select register (address 4) reads as 0 from the port register.
- R8: A pin with its change-enable bit set whose read value differs from the reference sets `chg_flag`. Pins whose change-enable bit is clear never set it.
- R9: Every read or write of address 0 records the current port read value as the new reference.
- R10: `chg_flag` stays set until a write to address 5 with bit 1 = 0. Writing 1 to that bit has no effect. A difference present in the same cycle as the clear wins, so the flag stays set.
- R11: Addresses 6 and 7 read 0. Bits 7:6 of every register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write mask for port writes |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 6 | Pin levels from the pads |
| pad_out | output | 6 | Output latch value to the pads |
| pad_oe | output | 6 | Per-pin driver enable |
| pad_pu | output | 6 | Per-pin pull-up enable |
| chg_flag | output | 1 | Sticky pin-change flag |

## Verification
A table of pin patterns is read back with different analog-select masks. Alternating, full and empty patterns show whether the pin mapping and the analog masking are correct bit by bit. Port writes with a partial mask over mixed pin levels show whether masked bits take the written data and unmasked bits take the pin levels. The change tests move one watched pin and one unwatched pin. They clear the flag with a difference still present and again after a port read or write, which shows whether the flag compares against the last access and not against the previous cycle. Pull-up tests step through the global disable, the direction register and the enables to show the three-way gating.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT  = 3'd0,
        REG_DIR   = 3'd1,
        REG_PUEN  = 3'd2,
        REG_CHGEN = 3'd3,
        REG_ANSEL = 3'd4,
        REG_CTRL  = 3'd5
    } reg_sel_e;

    localparam int unsigned CTRL_PUDIS_BIT = 0;
    localparam int unsigned CTRL_FLAG_BIT  = 1;

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] puen;
        logic [DATA_W-1:0] chgen;
        logic [DATA_W-1:0] ansel;
        logic              pu_dis;
    } port_cfg_t;

    function automatic logic [DATA_W-1:0] rmw_merge(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wr,
        input logic [DATA_W-1:0] mask
    );
        return (cur & ~mask) | (wr & mask);
    endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= '0;
            else     stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ioc_regs.sv
module ioc_regs import ioc_pkg::*; #(
    parameter int unsigned PINS       = 6,
    parameter int unsigned INPUT_ONLY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    input  logic [PINS-1:0]   pin_view,
    input  logic              flag,
    output port_cfg_t         cfg,
    output logic [PINS-1:0]   latch_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              port_access,
    output logic              flag_clr
);
    localparam logic [DATA_W-1:0] IMPL8 = DATA_W'((1 << PINS) - 1);
    localparam logic [DATA_W-1:0] ONLY8 = DATA_W'(1) << INPUT_ONLY;
    localparam logic [DATA_W-1:0] IO8   = IMPL8 & ~ONLY8;

    logic [DATA_W-1:0] view8;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] latch_next;
    reg_sel_e          sel;

    assign sel         = reg_sel_e'(bus_addr);
    assign view8       = DATA_W'(pin_view);
    assign port_access = (bus_wr || bus_rd) && (sel == REG_PORT);
    assign flag_clr    = bus_wr && (sel == REG_CTRL) && !bus_wdata[CTRL_FLAG_BIT];
    assign latch_next  = rmw_merge(view8, bus_wdata, bus_wmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.dir    <= IMPL8;
            cfg.puen   <= IO8;
            cfg.chgen  <= '0;
            cfg.ansel  <= '0;
            cfg.pu_dis <= 1'b1;
            latch_q    <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_PORT:  latch_q    <= latch_next[PINS-1:0];
                REG_DIR:   cfg.dir    <= (bus_wdata & IMPL8) | ONLY8;
                REG_PUEN:  cfg.puen   <= bus_wdata & IO8;
                REG_CHGEN: cfg.chgen  <= bus_wdata & IMPL8;
                REG_ANSEL: cfg.ansel  <= bus_wdata & IMPL8;
                REG_CTRL:  cfg.pu_dis <= bus_wdata[CTRL_PUDIS_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_PORT:  rd_mux = view8;
            REG_DIR:   rd_mux = cfg.dir;
            REG_PUEN:  rd_mux = cfg.puen;
            REG_CHGEN: rd_mux = cfg.chgen;
            REG_ANSEL: rd_mux = cfg.ansel;
            REG_CTRL: begin
                rd_mux[CTRL_PUDIS_BIT] = cfg.pu_dis;
                rd_mux[CTRL_FLAG_BIT]  = flag;
            end
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end
endmodule

// File: rtl/ioc_chg.sv
module ioc_chg #(
    parameter int unsigned PINS = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] view,
    input  logic [PINS-1:0] watch,
    input  logic            access,
    input  logic            clr,
    output logic            mismatch,
    output logic            flag_q
);
    logic [PINS-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst)         ref_q <= '0;
        else if (access) ref_q <= view;
    end

    assign mismatch = |((view ^ ref_q) & watch);

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (mismatch) flag_q <= 1'b1;
        else if (clr)      flag_q <= 1'b0;
    end
endmodule

// File: rtl/ioc_port.sv
module ioc_port import ioc_pkg::*; #(
    parameter int unsigned PINS        = 6,
    parameter int unsigned INPUT_ONLY  = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pu,
    output logic              chg_flag
);
    port_cfg_t       cfg;
    logic [PINS-1:0] pins_sync;
    logic [PINS-1:0] pin_view;
    logic [PINS-1:0] dir_v;
    logic            port_access;
    logic            flag_clr;
    logic            chg_mismatch;

    ioc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    assign pin_view = pins_sync & ~cfg.ansel[PINS-1:0];
    assign dir_v    = cfg.dir[PINS-1:0];

    ioc_regs #(.PINS(PINS), .INPUT_ONLY(INPUT_ONLY)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_wmask   (bus_wmask),
        .pin_view    (pin_view),
        .flag        (chg_flag),
        .cfg         (cfg),
        .latch_q     (pad_out),
        .rdata_q     (bus_rdata),
        .port_access (port_access),
        .flag_clr    (flag_clr)
    );

    ioc_chg #(.PINS(PINS)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .view     (pin_view),
        .watch    (cfg.chgen[PINS-1:0]),
        .access   (port_access),
        .clr      (flag_clr),
        .mismatch (chg_mismatch),
        .flag_q   (chg_flag)
    );

    assign pad_oe = ~dir_v;
    assign pad_pu = cfg.puen[PINS-1:0] & dir_v & {PINS{~cfg.pu_dis}};
endmodule

// File: rtl/ioc_port_chk.sv
module ioc_port_chk import ioc_pkg::*; #(
    parameter int unsigned PINS       = 6,
    parameter int unsigned INPUT_ONLY = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_pu,
    input logic              chg_flag,
    input logic              chg_mismatch
);
    localparam logic [PINS-1:0] ONLY_BIT = PINS'(1) << INPUT_ONLY;

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0) && !chg_flag && (pad_pu == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=>
            pad_oe == (~$past(bus_wdata[PINS-1:0]) & ~ONLY_BIT));

    p_input_only_r3: assert property (@(posedge clk) disable iff (rst)
        !pad_oe[INPUT_ONLY] && !pad_pu[INPUT_ONLY]);

    p_pull_on_input_r6: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_flag) |-> $past(chg_mismatch));

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (chg_flag && !(bus_wr && bus_addr == REG_CTRL && !bus_wdata[CTRL_FLAG_BIT]))
            |=> chg_flag);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        chg_mismatch |=> chg_flag);

    p_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata >> PINS) == '0);
endmodule

bind ioc_port ioc_port_chk #(.PINS(PINS), .INPUT_ONLY(INPUT_ONLY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_oe       (pad_oe),
    .pad_pu       (pad_pu),
    .chg_flag     (chg_flag),
    .chg_mismatch (chg_mismatch)
);

// File: tb/ioc_port_bench.sv
module ioc_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_wmask = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_out, pad_oe, pad_pu;
    logic       chg_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ioc_port u_ioc_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .chg_flag(chg_flag)
    );

    // pads[19:14], analog mask[13:8], expected port read[7:0]
    localparam logic [19:0] VEC [6] = '{
        {6'b101010, 6'b000000, 8'h2A},
        {6'b010101, 6'b000000, 8'h15},
        {6'b111111, 6'b000011, 8'h3C},
        {6'b111111, 6'b110000, 8'h0F},
        {6'b000000, 6'b000000, 8'h00},
        {6'b110011, 6'b010001, 8'h22}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
        check("R1 pad_pu", {2'b0, pad_pu}, 8'h00);
        check("R1 flag", {7'b0, chg_flag}, 8'h00);
        rd(3'd1, r); check("R1 dir", r, 8'h3F);
        rd(3'd2, r); check("R1 puen", r, 8'h37);
        rd(3'd5, r); check("R1 ctrl", r, 8'h01);
        rd(3'd3, r); check("R1 chgen", r, 8'h00);

        // R4 / R7 table of pin patterns and analog masks
        foreach (VEC[i]) begin
            wr(3'd4, {2'b0, VEC[i][13:8]}, 8'h00);
            pad_in = VEC[i][19:14];
            settle();
            rd(3'd0, r);
            check("R4_R7 port read", r, VEC[i][7:0]);
        end
        wr(3'd4, 8'h00, 8'h00);

        // R2 direction and latch drive
        wr(3'd1, 8'h38, 8'h00);
        check("R2 pad_oe", {2'b0, pad_oe}, 8'h07);
        // R5 masked port write, unmasked bits from pins
        pad_in = 6'b101010;
        settle();
        wr(3'd0, 8'h05, 8'h0F);
        check("R5 latch merge", {2'b0, pad_out}, 8'h25);
        wr(3'd0, 8'h00, 8'h3F);
        check("R5 full mask", {2'b0, pad_out}, 8'h00);

        // R3 input-only pin
        wr(3'd1, 8'h00, 8'h00);
        rd(3'd1, r); check("R3 dir bit3", r, 8'h08);
        check("R3 pad_oe", {2'b0, pad_oe}, 8'h37);
        wr(3'd2, 8'hFF, 8'h00);
        rd(3'd2, r); check("R3 puen bit3", r, 8'h37);

        // R6 pull-up gating
        wr(3'd1, 8'h3F, 8'h00);
        check("R6 global disable", {2'b0, pad_pu}, 8'h00);
        wr(3'd5, 8'h00, 8'h00);
        check("R6 enabled inputs", {2'b0, pad_pu}, 8'h37);
        wr(3'd1, 8'h30, 8'h00);
        check("R6 outputs no pull", {2'b0, pad_pu}, 8'h30);
        wr(3'd2, 8'h01, 8'h00);
        check("R6 enable on output", {2'b0, pad_pu}, 8'h00);

        // R11 unmapped and upper bits
        rd(3'd6, r); check("R11 addr6", r, 8'h00);
        rd(3'd7, r); check("R11 addr7", r, 8'h00);
        wr(3'd3, 8'hFF, 8'h00);
        rd(3'd3, r); check("R11 upper bits", r, 8'h3F);

        // R8 / R9 / R10 change detection
        wr(3'd1, 8'h3F, 8'h00);
        wr(3'd3, 8'h02, 8'h00);
        pad_in = 6'b000000;
        settle();
        rd(3'd0, r);
        wr(3'd5, 8'h01, 8'h00);
        check("R8 idle flag", {7'b0, chg_flag}, 8'h00);
        pad_in = 6'b010000;
        settle();
        check("R8 unwatched pin", {7'b0, chg_flag}, 8'h00);
        pad_in = 6'b010010;
        settle();
        check("R8 watched pin", {7'b0, chg_flag}, 8'h01);
        wr(3'd5, 8'h01, 8'h00);
        check("R10 clear blocked by mismatch", {7'b0, chg_flag}, 8'h01);
        wr(3'd5, 8'h03, 8'h00);
        check("R10 write one no effect", {7'b0, chg_flag}, 8'h01);
        rd(3'd0, r);
        check("R9 read value", r, 8'h12);
        wr(3'd5, 8'h01, 8'h00);
        check("R9_R10 clear after read", {7'b0, chg_flag}, 8'h00);
        rd(3'd5, r); check("R10 ctrl flag bit", r, 8'h01);
        pad_in = 6'b010000;
        settle();
        check("R8 return change", {7'b0, chg_flag}, 8'h01);
        repeat (5) @(negedge clk);
        check("R10 sticky", {7'b0, chg_flag}, 8'h01);
        wr(3'd0, 8'h00, 8'h00);
        wr(3'd5, 8'h01, 8'h00);
        check("R9 clear after write", {7'b0, chg_flag}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule